// File: doc/BRIEF.md
# Masked Event Interrupt Collector with Clear-on-Read

This block gathers single-cycle event pulses into a sticky flag register and raises an active-low interrupt request whenever a flag is set whose enable bit is also set. Flags are recorded whether or not they are enabled, so software can poll events it does not want interrupts for. In a metering front end, flag 0 marks the active-energy accumulator reaching half scale, flag 1 the reactive-energy accumulator and flag 2 the apparent-energy accumulator. The other flags are free for further sources.

Software reaches the block through a small register window. Address 0x18 holds the enable mask and can be written and read. Address 0x19 returns the flags and leaves them unchanged. Address 0x1A returns the flags and clears them. A read is framed by a start strobe and a completion strobe, because the serial transport needs many cycles to shift the value out.

The value returned is captured at the start strobe. For a clearing read, only the bits in that capture are cleared, and only at the completion strobe. The request is therefore released only when the clearing read finishes. An event that lands while the read is still in flight stays recorded and can drive the request again.

Top module: `irq_collector`

## Requirements
- R1: After reset the flags and the mask are all zero, `rd_data` is zero and `irq_n` is 1.
- R2: An event pulse on bit i of `evt_i` sets flag i on the next clock edge, whatever the mask holds. The flag then stays set until a clearing read removes it.
- R3: `irq_n` is 0 exactly when at least one flag is set whose mask bit is 1. It falls only after an event pulse or a mask write.
- R4: A write with `wr_addr` = 0x18 loads `wr_data` into the mask. A write to any other address leaves the mask unchanged.
- R5: A read started at 0x19 returns the flags as they stood before the start edge. A read started at 0x18 returns the mask. Neither read changes any flag.
- R6: A read started at 0x1A returns the flags as they stood before the start edge. At the completion strobe it clears exactly the returned bits, so the request is released at that point if nothing else is pending.
- R7: An event that arrives in the same cycle as the start strobe of a clearing read, between its start and completion strobes, or in the same cycle as its completion strobe, survives the clear and re-asserts the request if it is enabled.
- R8: A read started at any address other than 0x18, 0x19 or 0x1A returns zero and clears nothing.
- R9: A completion strobe with no clearing read outstanding has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | W | One-cycle event pulses, one per flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | W | Write data |
| rd_start | input | 1 | Read start strobe; captures the read value |
| rd_addr | input | AW | Read address, sampled with `rd_start` |
| rd_done | input | 1 | Read completion strobe |
| rd_data | output | W | Value captured at the last read start |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Directed sequences place events masked and unmasked. They place events on the start edge, inside the read window and on the completion edge of a clearing read, which tells a clear of the captured bits apart from a clear of the whole register. Plain reads, unmapped reads, stray completion strobes and mask writes to neighbouring addresses show that these leave flags and mask intact. A long random phase mixes overlapping reads, back-to-back starts and coincident start and completion strobes. A reference model checks `rd_data` and `irq_n` after every cycle.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int W = 24,
  parameter int AW = 7,
  parameter logic [AW-1:0] MASK_ADDR  = 'h18,
  parameter logic [AW-1:0] STAT_ADDR  = 'h19,
  parameter logic [AW-1:0] RSTAT_ADDR = 'h1A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  evt_i,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_start,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_done,
  output logic [W-1:0]  rd_data,
  output logic          irq_n
);

  logic [W-1:0] status_q, mask_q, clr_bits, rd_value;
  logic         pend_q;

  assign clr_bits = (rd_done && pend_q) ? rd_data : '0;
  assign irq_n    = ~|(status_q & mask_q);

  always_comb begin
    case (rd_addr)
      MASK_ADDR:              rd_value = mask_q;
      STAT_ADDR, RSTAT_ADDR:  rd_value = status_q;
      default:                rd_value = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      rd_data  <= '0;
      pend_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_bits) | evt_i;
      if (wr_en && wr_addr == MASK_ADDR)
        mask_q <= wr_data;
      if (rd_start) begin
        rd_data <= rd_value;
        pend_q  <= (rd_addr == RSTAT_ADDR);
      end else if (rd_done) begin
        pend_q  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk #(
  parameter int W = 24,
  parameter int AW = 7,
  parameter logic [AW-1:0] MASK_ADDR = 'h18
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  evt_i,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rd_done,
  input logic [W-1:0]  rd_data,
  input logic          irq_n,
  input logic [W-1:0]  status_q,
  input logic [W-1:0]  mask_q,
  input logic          pend_q
);

  assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(evt_i != '0 || wr_en));

  assert_mask_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != MASK_ADDR) |=> $stable(mask_q));

  assert_clear_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && pend_q) |=> ((status_q & $past(rd_data & ~evt_i)) == '0));

  assert_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !pend_q) |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

bind irq_collector irq_collector_chk #(.W(W), .AW(AW), .MASK_ADDR(MASK_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_done(rd_done), .rd_data(rd_data), .irq_n(irq_n),
  .status_q(status_q), .mask_q(mask_q), .pend_q(pend_q)
);

// File: tb/irq_collector_bench.sv
`timescale 1ns/1ps
module irq_collector_bench;
  localparam int W = 24;
  localparam int AW = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [W-1:0]  evt_i = '0;
  logic          wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_start = 0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_done = 0;
  logic [W-1:0]  rd_data;
  logic          irq_n;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  logic [W-1:0] m_status = '0, m_mask = '0, m_rdata = '0;
  logic         m_pend = 0;

  always #2 clk = ~clk;

  irq_collector #(.W(W), .AW(AW)) u_irq_collector (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_start(rd_start), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic logic [W-1:0] read_value(input logic [AW-1:0] a,
                                              input logic [W-1:0] st, input logic [W-1:0] mk);
    if (a == 7'h18) return mk;
    if (a == 7'h19 || a == 7'h1A) return st;
    return '0;
  endfunction

  function automatic logic exp_irq_n(input logic [W-1:0] st, input logic [W-1:0] mk);
    return ~|(st & mk);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] ev, input logic we, input logic [AW-1:0] wa,
                      input logic [W-1:0] wd, input logic rs, input logic [AW-1:0] ra,
                      input logic rdn, input string tag);
    logic [W-1:0] clr, ost, omk;
    @(negedge clk);
    evt_i = ev; wr_en = we; wr_addr = wa; wr_data = wd;
    rd_start = rs; rd_addr = ra; rd_done = rdn;
    @(posedge clk);
    ost = m_status; omk = m_mask;
    clr = (rdn && m_pend) ? m_rdata : '0;
    m_status = (ost & ~clr) | ev;
    if (we && wa == 7'h18) m_mask = wd;
    if (rs) begin
      m_rdata = read_value(ra, ost, omk);
      m_pend  = (ra == 7'h1A);
    end else if (rdn) m_pend = 0;
    #1;
    check(rd_data === m_rdata, {tag, " rd_data"}, rd_data, m_rdata);
    check(irq_n === exp_irq_n(m_status, m_mask), {tag, " irq_n"},
          {{(W-1){1'b0}}, irq_n}, {{(W-1){1'b0}}, exp_irq_n(m_status, m_mask)});
  endtask

  task automatic idle(input string tag);
    step('0, 0, '0, '0, 0, '0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    #9;
    check(rd_data === '0, "R1 reset rd_data", rd_data, '0);
    check(irq_n === 1'b1, "R1 reset irq_n", {{(W-1){1'b0}}, irq_n}, 1);
    @(negedge clk); rst_n = 1;
    step('0, 0, '0, '0, 1, 7'h19, 0, "R1 status read");
    step('0, 0, '0, '0, 1, 7'h18, 1, "R1 mask read");
    check(rd_data === '0, "R1 mask zero", rd_data, '0);

    // R2: masked event still recorded
    step(24'h000020, 0, '0, '0, 0, '0, 0, "R2 masked event");
    check(irq_n === 1'b1, "R2 masked no irq", {{(W-1){1'b0}}, irq_n}, 1);
    step('0, 0, '0, '0, 1, 7'h19, 0, "R2 read");
    step('0, 0, '0, '0, 0, '0, 1, "R2 done");
    check(rd_data === 24'h000020, "R2 flag visible", rd_data, 24'h000020);

    // R4: neighbouring addresses ignored
    step('0, 1, 7'h17, '1, 0, '0, 0, "R4 write 0x17");
    step('0, 1, 7'h19, '1, 0, '0, 0, "R4 write 0x19");
    check(irq_n === 1'b1, "R4 mask untouched", {{(W-1){1'b0}}, irq_n}, 1);
    step('0, 1, 7'h18, 24'h000027, 0, '0, 0, "R3 R4 mask write");
    check(irq_n === 1'b0, "R3 irq asserted", {{(W-1){1'b0}}, irq_n}, 0);
    step('0, 0, '0, '0, 1, 7'h18, 1, "R4 mask readback");
    check(rd_data === 24'h000027, "R4 mask value", rd_data, 24'h000027);

    // R5: plain read keeps flags
    step('0, 0, '0, '0, 1, 7'h19, 0, "R5 start");
    step('0, 0, '0, '0, 0, '0, 1, "R5 done");
    check(irq_n === 1'b0, "R5 no clear", {{(W-1){1'b0}}, irq_n}, 0);

    // R8 and R9
    step('0, 0, '0, '0, 1, 7'h05, 0, "R8 unmapped start");
    check(rd_data === '0, "R8 zero data", rd_data, '0);
    step('0, 0, '0, '0, 0, '0, 1, "R8 unmapped done");
    step('0, 0, '0, '0, 0, '0, 1, "R9 stray done");
    check(irq_n === 1'b0, "R9 flags kept", {{(W-1){1'b0}}, irq_n}, 0);

    // R6 / R7: clearing read with events racing it
    step(24'h000200, 0, '0, '0, 1, 7'h1A, 0, "R7 event on start");
    check(rd_data === 24'h000020, "R6 snapshot", rd_data, 24'h000020);
    step(24'h000002, 0, '0, '0, 0, '0, 0, "R7 event inside");
    step(24'h000004, 0, '0, '0, 0, '0, 1, "R6 R7 done with event");
    check(irq_n === 1'b0, "R7 request re-asserted", {{(W-1){1'b0}}, irq_n}, 0);
    step('0, 0, '0, '0, 1, 7'h19, 1, "R7 survivors");
    check(rd_data === 24'h000206, "R7 survivors value", rd_data, 24'h000206);
    step('0, 0, '0, '0, 1, 7'h1A, 0, "R6 second start");
    step('0, 0, '0, '0, 0, '0, 1, "R6 second done");
    check(irq_n === 1'b1, "R6 released", {{(W-1){1'b0}}, irq_n}, 1);
    step('0, 0, '0, '0, 1, 7'h19, 1, "R6 empty");
    check(rd_data === '0, "R6 all cleared", rd_data, '0);

    // random phase: R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] ev, wd;
      logic [AW-1:0] wa, ra;
      logic we, rs, rdn;
      ev = ($urandom % 6 == 0) ? (24'h1 << ($urandom % W)) : '0;
      we = ($urandom % 10 == 0);
      wa = 7'h17 + 7'($urandom % 3);
      wd = 24'($urandom);
      rs = ($urandom % 5 == 0);
      case ($urandom % 4)
        0: ra = 7'h18;
        1: ra = 7'h19;
        2: ra = 7'h1A;
        default: ra = 7'h05;
      endcase
      rdn = ($urandom % 4 == 0);
      step(ev, we, wa, wd, rs, ra, rdn, "R2 R3 R6 R7 random");
    end
    idle("final");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule